// File: doc/BRIEF.md
# Serial Master Clock Generator and Byte Shifter

This block is the timing and data core of a serial-peripheral master. A fast peripheral clock drives it. A programmable baud value sets the serial clock (SCLK), whose period is a whole number of fast cycles. On each accepted start request the block moves one 8-bit character. It sends the transmit byte on MOSI, most significant bit first, and assembles the byte arriving on MISO. It then raises a one-cycle done flag, and at that point the received byte is valid.

Only clock phase 0 is supported. A polarity input picks whether SCLK rests low or high. The first half of every serial period is spent at the non-idle (active) level. When the period is odd, that active half is the shorter one. The launching edge is the transition into the active level, and MOSI moves only there. The sampling edge is the transition back to idle, and MISO is captured there.

A four-state controller sequences the transfer:
- `ST_IDLE` waits for a start request.
- `ST_SETUP` holds SCLK idle for one trailing-length half-period after the start, with the first bit already on MOSI.
- `ST_LEAD` is the active phase.
- `ST_TRAIL` is the idle phase between bits.

The transitions are:
- accept: `ST_IDLE` to `ST_SETUP`
- first edge: `ST_SETUP` to `ST_LEAD`
- sample: `ST_LEAD` to `ST_TRAIL`
- launch: `ST_TRAIL` to `ST_LEAD`
- finish: `ST_LEAD` to `ST_IDLE`, on the eighth sample

Top module: `spim_engine`

## Requirements
- R1: Baud values 0, 1 and 2 all give an SCLK period N of 4 fast clock cycles.
- R2: A baud value B of 3 or more gives an SCLK period N of B+1 fast cycles (4 to 128 for the 7-bit baud input).
- R3: Each period starts with an active phase of floor(N/2) cycles and ends with an idle-level phase of ceil(N/2) cycles, so for odd N the active phase is one cycle shorter.
- R4: With polarity 0, SCLK rests low and is high in the active phase. With polarity 1, SCLK rests high and is low in the active phase. While no transfer runs, SCLK follows the polarity input one cycle later.
- R5: Take the clock edge that accepts the start as cycle 0. Bit 7 of the transmit byte is on MOSI from cycle 0 on. The first active phase begins at cycle ceil(N/2). Every later transition into the active level puts the next lower bit on MOSI, and MOSI changes at no other time during the transfer.
- R6: MISO is captured at each transition from the active level back to idle. The first captured bit becomes bit 7 of the received byte.
- R7: The done output is high for exactly one cycle, at cycle 8N. In that cycle the received byte output holds all eight captured bits.
- R8: A start request while a transfer is running is ignored. Baud, polarity and transmit byte are taken only at the accepted start, so changing them during a transfer has no effect on SCLK, MOSI or timing.
- R9: After the eighth sample, SCLK stays at the idle level until the next accepted start.
- R10: During reset, SCLK, MOSI, done and the received byte are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_sel | input | 7 | Baud value B; period is max(4, B+1) for B≥3, else 4 |
| cpol | input | 1 | Idle level of SCLK |
| tx_byte | input | 8 | Character to send |
| start | input | 1 | Start request, taken when idle |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| rx_byte | output | 8 | Last received character |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench sweeps every small baud value, including the three clamped ones, and the largest divisors, under both polarities. For each fast cycle of each transfer it predicts SCLK and MOSI from the period arithmetic. A design that split odd periods the wrong way, or that failed to clamp baud values 0 to 2, would show SCLK transitions one or more cycles off. A model slave moves MISO on launching edges only, so capturing on the wrong edge returns a shifted byte. The bench issues a second start mid-transfer with a new byte, polarity and baud; a design that honoured it would restart or re-time the waveform and raise done at the wrong cycle.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LEAD  = 2'd2,
        ST_TRAIL = 2'd3
    } spim_state_t;

    // Shortest serial period in fast cycles, and the baud value below which it is forced.
    localparam int MIN_PERIOD = 4;
    localparam int CLAMP_BELOW = 3;

endpackage

// File: rtl/spim_phase_timer.sv
module spim_phase_timer #(
    parameter int BAUD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BAUD_W-1:0] baud_in,
    input  logic              load_lead,
    input  logic              load_trail,
    output logic              expired
);
    import spim_pkg::*;

    localparam int PW = BAUD_W + 1;

    logic [BAUD_W-1:0] baud_q;
    logic [BAUD_W-1:0] baud_cur;
    logic [PW-1:0]     period;
    logic [PW-1:0]     len_lead;
    logic [PW-1:0]     len_trail;
    logic [PW-1:0]     cnt;

    assign baud_cur = go ? baud_in : baud_q;

    always_comb begin
        if (baud_cur < BAUD_W'(CLAMP_BELOW))
            period = PW'(MIN_PERIOD);
        else
            period = {1'b0, baud_cur} + PW'(1);
        len_lead  = period >> 1;
        len_trail = period - len_lead;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            baud_q <= '0;
            cnt    <= '0;
        end else begin
            if (go)
                baud_q <= baud_in;
            if (load_lead)
                cnt <= len_lead - PW'(1);
            else if (load_trail)
                cnt <= len_trail - PW'(1);
            else if (cnt != '0)
                cnt <= cnt - PW'(1);
        end
    end

    assign expired = (cnt == '0);

    // R2: period stays in the legal 4..2^BAUD_W window
    always_comb begin
        if (rst_n)
            a_r2_period_range : assert (period >= PW'(MIN_PERIOD) && period <= PW'(2 ** BAUD_W));
    end

    // R3: the active half is the shorter one, by at most one cycle
    always_comb begin
        if (rst_n)
            a_r3_uneven_split : assert (len_lead <= len_trail && (len_trail - len_lead) <= PW'(1));
    end

    // R8: the latched baud value only changes on an accepted start
    a_r8_baud_held : assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(baud_q));

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl #(
    parameter int CHAR_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cpol,
    input  logic tmr_expired,
    output logic go,
    output logic load_lead,
    output logic load_trail,
    output logic launch,
    output logic sample,
    output logic finish,
    output logic sclk,
    output logic done
);
    import spim_pkg::*;

    localparam int BC_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;

    spim_state_t     state, state_nx;
    logic [BC_W-1:0] bit_cnt;
    logic            cpol_q;
    logic            last_bit;
    logic            pol_eff;

    assign last_bit = (bit_cnt == BC_W'(CHAR_W - 1));

    always_comb begin
        state_nx   = state;
        go         = 1'b0;
        load_lead  = 1'b0;
        load_trail = 1'b0;
        launch     = 1'b0;
        sample     = 1'b0;
        finish     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    go         = 1'b1;
                    load_trail = 1'b1;
                    state_nx   = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    load_lead = 1'b1;
                    state_nx  = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tmr_expired) begin
                    sample = 1'b1;
                    if (last_bit) begin
                        finish   = 1'b1;
                        state_nx = ST_IDLE;
                    end else begin
                        load_trail = 1'b1;
                        state_nx   = ST_TRAIL;
                    end
                end
            end
            ST_TRAIL: begin
                if (tmr_expired) begin
                    launch    = 1'b1;
                    load_lead = 1'b1;
                    state_nx  = ST_LEAD;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register, bit counter and latched polarity
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            cpol_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (go) begin
                bit_cnt <= '0;
                cpol_q  <= cpol;
            end else if (launch) begin
                bit_cnt <= bit_cnt + BC_W'(1);
            end
        end
    end

    assign pol_eff = (state == ST_IDLE) ? cpol : cpol_q;

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk <= 1'b0;
            done <= 1'b0;
        end else begin
            sclk <= (state_nx == ST_LEAD) ? ~pol_eff : pol_eff;
            done <= finish;
        end
    end

    // R7: done never lasts two cycles
    a_r7_done_single : assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: when done is shown the clock is back at its idle level
    a_r9_idle_at_done : assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sclk == cpol_q));

    // R8: a start while busy leaves the latched polarity untouched
    a_r8_busy_start_ignored : assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(cpol_q));

    // R4: in the active phase SCLK sits opposite the latched polarity
    a_r4_active_level : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD) |-> (sclk != cpol_q));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CHAR_W-1:0] tx_byte,
    input  logic              launch,
    input  logic              sample,
    input  logic              finish,
    input  logic              miso,
    output logic              mosi,
    output logic [CHAR_W-1:0] rx_byte
);
    logic [CHAR_W-1:0] tx_sr;
    logic [CHAR_W-1:0] rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            rx_byte <= '0;
        end else begin
            if (go)
                tx_sr <= tx_byte;
            else if (launch)
                tx_sr <= {tx_sr[CHAR_W-2:0], 1'b0};
            if (go)
                rx_sr <= '0;
            else if (sample)
                rx_sr <= {rx_sr[CHAR_W-2:0], miso};
            if (finish)
                rx_byte <= {rx_sr[CHAR_W-2:0], miso};
        end
    end

    assign mosi = tx_sr[CHAR_W-1];

    // R5: the MSB of the accepted byte is on the line right after the start
    a_r5_first_bit : assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (mosi == $past(tx_byte[CHAR_W-1])));

    // R5: MOSI only moves on a launch or a start
    a_r5_mosi_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !launch) |=> $stable(mosi));

endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
    parameter int BAUD_W = 7,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BAUD_W-1:0] baud_sel,
    input  logic              cpol,
    input  logic [CHAR_W-1:0] tx_byte,
    input  logic              start,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [CHAR_W-1:0] rx_byte,
    output logic              done
);
    logic go;
    logic load_lead;
    logic load_trail;
    logic launch;
    logic sample;
    logic finish;
    logic tmr_expired;

    spim_ctrl #(.CHAR_W(CHAR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cpol        (cpol),
        .tmr_expired (tmr_expired),
        .go          (go),
        .load_lead   (load_lead),
        .load_trail  (load_trail),
        .launch      (launch),
        .sample      (sample),
        .finish      (finish),
        .sclk        (sclk),
        .done        (done)
    );

    spim_phase_timer #(.BAUD_W(BAUD_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .baud_in    (baud_sel),
        .load_lead  (load_lead),
        .load_trail (load_trail),
        .expired    (tmr_expired)
    );

    spim_shifter #(.CHAR_W(CHAR_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .tx_byte (tx_byte),
        .launch  (launch),
        .sample  (sample),
        .finish  (finish),
        .miso    (miso),
        .mosi    (mosi),
        .rx_byte (rx_byte)
    );

endmodule

// File: tb/spim_engine_bench.sv
module spim_engine_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] baud_sel = '0;
    logic       cpol = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       start = 1'b0;
    logic       miso = 1'b0;
    logic       sclk;
    logic       mosi;
    logic [7:0] rx_byte;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spim_engine u_spim_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .baud_sel (baud_sel),
        .cpol     (cpol),
        .tx_byte  (tx_byte),
        .start    (start),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .rx_byte  (rx_byte),
        .done     (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual %0d expected below %0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // One transfer; cycle c is the negedge after the c-th posedge counted from the accepting one
    task automatic run_xfer(input int b, input bit pol, input logic [7:0] tx, input logic [7:0] pat);
        int n;
        int l1;
        int l2;
        int launches;
        bit prev;
        n  = (b < 3) ? 4 : b + 1;
        l1 = n / 2;
        l2 = n - l1;
        @(negedge clk);
        baud_sel = 7'(b);
        cpol     = pol;
        tx_byte  = tx;
        start    = 1'b1;
        miso     = pat[7];
        prev     = pol;
        launches = 0;
        for (int c = 0; c <= 8 * n + 1; c++) begin
            bit exp_sclk;
            int idx;
            @(negedge clk);
            if (c == 0) start = 1'b0;
            // mid-transfer start with altered settings must be ignored (R8)
            if (c == 3 * n) begin
                start    = 1'b1;
                tx_byte  = ~tx;
                cpol     = ~pol;
                baud_sel = 7'(b + 5);
            end
            if (c == 3 * n + 1) begin
                start = 1'b0;
                cpol  = pol;
            end
            exp_sclk = (c >= l2 && c < 8 * n && ((c - l2) % n) < l1) ? ~pol : pol;
            // R1 R2 R3 R4 R9: SCLK waveform from the period arithmetic
            chk(sclk == exp_sclk, "R1/R2 R3 R4 R9 sclk", int'(sclk), int'(exp_sclk));
            if (c <= 8 * n) begin
                idx = (c < l2 + n) ? 0 : (c - l2) / n;
                if (idx > 7) idx = 7;
                // R5: MSB first, first bit from cycle 0
                chk(mosi == tx[7 - idx], "R5 mosi", int'(mosi), int'(tx[7 - idx]));
            end
            if (c == 8 * n) begin
                // R7 R6: done pulse and received byte
                chk(done == 1'b1, "R7 done high", int'(done), 1);
                chk(rx_byte == pat, "R6 rx_byte", int'(rx_byte), int'(pat));
            end else begin
                chk(done == 1'b0, "R7 R8 done low", int'(done), 0);
            end
            // model slave: shifts on every launching edge after the first
            if (sclk != pol && prev == pol) begin
                launches++;
                if (launches >= 2 && launches <= 8) miso = pat[8 - launches];
            end
            prev = sclk;
        end
        baud_sel = 7'(b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        chk(sclk == 1'b0, "R10 sclk", int'(sclk), 0);
        chk(mosi == 1'b0, "R10 mosi", int'(mosi), 0);
        chk(done == 1'b0, "R10 done", int'(done), 0);
        chk(rx_byte == 8'h00, "R10 rx_byte", int'(rx_byte), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: idle level follows polarity input
        cpol = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b1, "R4 idle high", int'(sclk), 1);
        cpol = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0, "R4 idle low", int'(sclk), 0);
        for (int p = 0; p < 2; p++) begin
            for (int b = 0; b <= 40; b++) begin
                logic [7:0] t;
                logic [7:0] r;
                t = 8'(b * 37 + p * 91 + 5);
                r = 8'(b * 113 + p * 29 + 200);
                run_xfer(b, p[0], t, r);
                repeat (b % 3) @(negedge clk);
            end
            run_xfer(63, p[0], 8'hA5, 8'h3C);
            run_xfer(64, p[0], 8'h5A, 8'hC3);
            run_xfer(126, p[0], 8'h81, 8'h7E);
            run_xfer(127, p[0], 8'hFF, 8'h00);
        end
        // R9: clock rests at idle with no start
        cpol = 1'b1;
        repeat (20) begin
            @(negedge clk);
            chk(sclk == 1'b1, "R9 rest", int'(sclk), 1);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule